// File: doc/BRIEF.md
# Programmable Square-Wave Interval Timer

A 14-bit down-counting interval timer. It is clocked by a timer input pulse stream and drives one timer output pin. The host programs it through a byte-wide register interface. Two offsets stage a count length and a two-bit output mode. A separate command write then starts or stops the timer. The timer can produce a single square wave, a continuous square wave, one low pulse at terminal count, or a repeating low pulse at every terminal count.

Inside, each output period is split into two half-periods. The counter steps down by two through each half and reaches its terminal state at the value 2. For an odd count, the high half is therefore one clock longer than the low half. Staged values never disturb a running count. A start command issued while the timer runs takes effect at the next terminal count. The live counter state can be read back, halved, through the same two offsets.

Top module: `prog_timer`

## Requirements
- R1: A write to offset 3'b100 stages count bits 7:0. A write to offset 3'b101 stages count bits 13:8 from data bits 5:0 and the mode from data bits 7:6. Staged values do not change a running timer until a START command is issued.
- R2: The mode is decoded from bits 7:6 of the offset 3'b101 write: 2'b00 gives one square wave, 2'b01 gives continuous square waves, 2'b10 gives one pulse, and 2'b11 gives continuous pulses.
- R3: In the square modes, a count N of at least 2 drives the output high for (N+1)/2 clocks and then low for N/2 clocks (integer division). The first high clock is the cycle right after the clock edge that samples the START command.
- R4: In the pulse modes, the output is high for N-1 clocks and low for exactly one clock at terminal count. The single modes stop after one period, and the output then stays high.
- R5: A START command given while the staged count is below 2 is ignored. A stopped timer holds its output high.
- R6: The command is decoded from cmd_wdata bits 7:6: 2'b00 is no operation, 2'b01 is STOP, 2'b10 is stop-after-terminal-count, and 2'b11 is START. Both stop commands do nothing when the timer is idle.
- R7: A START command issued while the timer runs captures the staged count and mode at that moment. The current period is completed first, and the captured values begin in the cycle after its terminal count.
- R8: STOP halts a running timer, and its output is high from the next clock.
- R9: Stop-after-terminal-count lets the current period finish and then leaves the timer idle with the output high.
- R10: Reset stops the timer. The output stays high until a START command is issued.
- R11: A read at offset 3'b100 returns bits 7:0 of the clocks left in the current half-period, which is the live counter halved. A read at offset 3'b101 returns the active mode in bits 7:6 and bits 13:8 of that value in bits 5:0. All other offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer input pulse clock; register and command writes are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Count-length register write strobe |
| reg_addr | input | 3 | Register offset for writes |
| reg_wdata | input | 8 | Register write data |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command byte; bits 7:6 carry the command |
| rd_addr | input | 3 | Readback offset |
| rd_data | output | 8 | Readback data for the live counter state |
| tmr_out | output | 1 | Timer output waveform |

## Verification
Every mode is swept over counts 2 to 24. Both even and odd counts are used, so the bench can tell a symmetric split from the one-clock-longer high half. The continuous modes run for three periods and the single modes for two, which separates reload from stop-after-one-period. The largest count, 16383, is run once to check the widest half-period and its readback. Directed sequences then place commands in the middle of a period. These are a deferred START with staged writes made both before and after it, STOP against stop-after-terminal-count, a NOP, a reset during a run, and START with counts of 0 and 1. Each of these shows whether a command acts at once, at terminal count, or not at all.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam int CNT_W   = 14;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int HALF_W  = CNT_W + 1;
    localparam int HI_W    = CNT_W - DATA_W;
    localparam int MIN_LEN = 2;

    localparam logic [ADDR_W-1:0] OFS_LEN_LO = 3'b100;
    localparam logic [ADDR_W-1:0] OFS_LEN_HI = 3'b101;

    typedef enum logic [1:0] {
        MODE_SQ_ONE = 2'b00,
        MODE_SQ_RUN = 2'b01,
        MODE_PL_ONE = 2'b10,
        MODE_PL_RUN = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        CMD_NOP     = 2'b00,
        CMD_HALT    = 2'b01,
        CMD_HALT_TC = 2'b10,
        CMD_GO      = 2'b11
    } tcmd_e;

    typedef struct packed {
        tmode_e           mode;
        logic [CNT_W-1:0] len;
    } tcfg_t;

    // counter value that starts the high half: rounds odd lengths up
    function automatic logic [HALF_W-1:0] first_half(input logic [CNT_W-1:0] len);
        return {1'b0, len} + {{(HALF_W-1){1'b0}}, len[0]};
    endfunction

    // counter value that starts the low half: rounds odd lengths down
    function automatic logic [HALF_W-1:0] second_half(input logic [CNT_W-1:0] len);
        return {1'b0, len} - {{(HALF_W-1){1'b0}}, len[0]};
    endfunction

    function automatic logic is_single(input tmode_e m);
        return ~m[0];
    endfunction

    function automatic logic is_pulse(input tmode_e m);
        return m[1];
    endfunction
endpackage

// File: rtl/timer_stage_regs.sv
module timer_stage_regs
    import timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output tcfg_t             staged
);
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (we) begin
            if (addr == OFS_LEN_LO) lo_q <= wdata;
            if (addr == OFS_LEN_HI) hi_q <= wdata;
        end
    end

    always_comb begin
        staged.len  = {hi_q[HI_W-1:0], lo_q};
        staged.mode = tmode_e'(hi_q[DATA_W-1:DATA_W-2]);
    end
endmodule

// File: rtl/timer_core.sv
module timer_core
    import timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  tcmd_e             cmd,
    input  tcfg_t             staged,
    output logic              run,
    output logic              phase,
    output logic              tc,
    output logic [HALF_W-1:0] cnt,
    output tcfg_t             act
);
    logic              run_q, run_d;
    logic              phase_q, phase_d;
    logic [HALF_W-1:0] cnt_q, cnt_d;
    tcfg_t             act_q, act_d;
    logic              pend_q, pend_d;
    tcfg_t             pcfg_q, pcfg_d;
    logic              stop_q, stop_d;
    logic              half_end, tc_now, do_load, legal;
    tcfg_t             load_cfg;

    localparam logic [HALF_W-1:0] TERM = HALF_W'(2);

    assign half_end = run_q && !phase_q && (cnt_q == TERM);
    assign tc_now   = run_q &&  phase_q && (cnt_q == TERM);
    assign legal    = (staged.len >= CNT_W'(MIN_LEN));

    always_comb begin
        run_d    = run_q;
        phase_d  = phase_q;
        cnt_d    = cnt_q;
        act_d    = act_q;
        pend_d   = pend_q;
        pcfg_d   = pcfg_q;
        stop_d   = stop_q;
        do_load  = 1'b0;
        load_cfg = pcfg_q;

        // counting step
        if (run_q) begin
            if (tc_now) begin
                if (pend_q) begin
                    do_load = 1'b1;
                end else if (stop_q || is_single(act_q.mode)) begin
                    run_d = 1'b0;
                end else begin
                    phase_d = 1'b0;
                    cnt_d   = first_half(act_q.len);
                end
            end else if (half_end) begin
                phase_d = 1'b1;
                cnt_d   = second_half(act_q.len);
            end else begin
                cnt_d = cnt_q - TERM;
            end
        end

        // START: immediate when idle or at terminal count, else deferred
        if (cmd_we && cmd == CMD_GO && legal) begin
            if (!run_q || tc_now) begin
                do_load  = 1'b1;
                load_cfg = staged;
            end else begin
                pend_d = 1'b1;
                pcfg_d = staged;
                stop_d = 1'b0;
            end
        end

        if (do_load) begin
            run_d   = 1'b1;
            phase_d = 1'b0;
            cnt_d   = first_half(load_cfg.len);
            act_d   = load_cfg;
            pend_d  = 1'b0;
            stop_d  = 1'b0;
        end

        if (cmd_we && cmd == CMD_HALT_TC && run_q) begin
            stop_d = 1'b1;
            pend_d = 1'b0;
        end
        if (cmd_we && cmd == CMD_HALT && run_q) begin
            run_d = 1'b0;
        end

        if (!run_d) begin
            pend_d = 1'b0;
            stop_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            phase_q <= 1'b0;
            cnt_q   <= '0;
            act_q   <= '0;
            pend_q  <= 1'b0;
            pcfg_q  <= '0;
            stop_q  <= 1'b0;
        end else begin
            run_q   <= run_d;
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            act_q   <= act_d;
            pend_q  <= pend_d;
            pcfg_q  <= pcfg_d;
            stop_q  <= stop_d;
        end
    end

    assign run   = run_q;
    assign phase = phase_q;
    assign tc    = tc_now;
    assign cnt   = cnt_q;
    assign act   = act_q;

    // R3: inside a half-period the counter falls by exactly two per clock
    a_r3_step_by_two: assert property (@(posedge clk) disable iff (rst)
        run_q && !tc_now && !half_end |=> !run_q || cnt_q == $past(cnt_q) - TERM);

    // R7: the active count and mode change only at terminal count or on a start from idle
    a_r7_hold_active: assert property (@(posedge clk) disable iff (rst)
        run_q && !tc_now |=> $stable(act_q));

    // R9: a pending stop-after-terminal-count ends the run at terminal count
    a_r9_stop_at_tc: assert property (@(posedge clk) disable iff (rst)
        tc_now && stop_q && !pend_q && !cmd_we |=> !run_q);

    // R10: the timer is idle right after reset
    a_r10_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !run_q);

    // R5: a running timer never holds a length below the minimum
    a_r5_legal_len: assert property (@(posedge clk) disable iff (rst)
        run_q |-> act_q.len >= CNT_W'(MIN_LEN));
endmodule

// File: rtl/timer_outdec.sv
module timer_outdec
    import timer_pkg::*;
(
    input  logic   run,
    input  logic   phase,
    input  logic   tc,
    input  tmode_e mode,
    output logic   wave
);
    always_comb begin
        if (!run)                wave = 1'b1;
        else if (is_pulse(mode)) wave = !tc;
        else                     wave = !phase;
    end
endmodule

// File: rtl/prog_timer.sv
module prog_timer
    import timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_we,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       cmd_we,
    input  logic [7:0] cmd_wdata,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       tmr_out
);
    tcfg_t             staged;
    tcfg_t             act;
    logic              run, phase, tc;
    logic [HALF_W-1:0] cnt;
    logic [CNT_W-1:0]  remain;
    tcmd_e             cmd;

    assign cmd = tcmd_e'(cmd_wdata[DATA_W-1:DATA_W-2]);

    timer_stage_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .staged (staged)
    );

    timer_core u_core (
        .clk    (clk),
        .rst    (rst),
        .cmd_we (cmd_we),
        .cmd    (cmd),
        .staged (staged),
        .run    (run),
        .phase  (phase),
        .tc     (tc),
        .cnt    (cnt),
        .act    (act)
    );

    timer_outdec u_out (
        .run   (run),
        .phase (phase),
        .tc    (tc),
        .mode  (act.mode),
        .wave  (tmr_out)
    );

    // halved counter: clocks left in the current half-period
    assign remain = cnt[HALF_W-1:1];

    always_comb begin
        case (rd_addr)
            OFS_LEN_LO: rd_data = remain[DATA_W-1:0];
            OFS_LEN_HI: rd_data = {act.mode, remain[CNT_W-1:DATA_W]};
            default:    rd_data = '0;
        endcase
    end

    // R5: an idle timer drives its output high
    a_r5_idle_high: assert property (@(posedge clk) disable iff (rst)
        !run |-> tmr_out);

    // R8: STOP leaves the output high on the next clock
    a_r8_halt_high: assert property (@(posedge clk) disable iff (rst)
        cmd_we && cmd_wdata[7:6] == 2'b01 |=> tmr_out);

    // R4: a pulse-mode low lasts one clock only
    a_r4_one_clock_pulse: assert property (@(posedge clk) disable iff (rst)
        is_pulse(act.mode) && !tmr_out |=> tmr_out);
endmodule

// File: tb/prog_timer_test.sv
module prog_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] LO = 3'b100;
    localparam logic [2:0] HI = 3'b101;
    localparam logic [1:0] C_NOP = 2'b00, C_HALT = 2'b01, C_HALT_TC = 2'b10, C_GO = 2'b11;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_wdata = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tmr_out;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_timer uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data), .tmr_out(tmr_out)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic load(input logic [1:0] m, input int n);
        wr_reg(LO, n[7:0]);
        wr_reg(HI, {m, n[13:8]});
    endtask

    task automatic cmd(input logic [1:0] c);
        cmd_we = 1'b1; cmd_wdata = {c, 6'b0};
        tick();
        cmd_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input int exp);
        rd_addr = a;
        #1;
        chk(tag, int'(rd_data), exp);
    endtask

    // expected output level on the i-th clock (from 1) after START
    function automatic int exp_wave(input int m, input int n, input int i);
        int p = (i - 1) / n;
        int k = (i - 1) % n + 1;
        if ((m % 2) == 0 && p >= 1) return 1;
        if (m < 2) return (k <= (n + 1) / 2) ? 1 : 0;
        return (k == n) ? 0 : 1;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        #1 chk("R10 reset output high", int'(tmr_out), 1);
        rd_chk("R11 other offset reads 0", 3'b000, 0);

        // R5: counts below 2 never start
        for (int n = 0; n < 2; n++) begin
            load(2'b01, n);
            cmd(C_GO);
            for (int i = 1; i <= 8; i++) begin
                if (i > 1) tick();
                #1 chk("R5 short count ignored", int'(tmr_out), 1);
            end
        end

        // R6: stop commands and NOP on an idle timer
        cmd(C_HALT);
        cmd(C_HALT_TC);
        cmd(C_NOP);
        #1 chk("R6 idle stop is no-op", int'(tmr_out), 1);

        // R2 R3 R4: sweep of every mode over small counts
        for (int m = 0; m < 4; m++) begin
            for (int n = 2; n <= 24; n++) begin
                int s = (m % 2 == 1) ? 3 * n : 2 * n;
                load(m[1:0], n);
                cmd(C_GO);
                for (int i = 1; i <= s; i++) begin
                    if (i > 1) tick();
                    #1 chk(m < 2 ? "R3 R2 square sweep" : "R4 R2 pulse sweep",
                           int'(tmr_out), exp_wave(m, n, i));
                end
                tick();
                cmd(C_HALT);
            end
        end

        // R11 R3: largest count, one square wave, with readback
        load(2'b00, 16383);
        cmd(C_GO);
        rd_chk("R11 max low byte", LO, 8'h00);
        rd_chk("R11 max high byte", HI, 8'h20);
        for (int i = 1; i <= 2 * 16383; i++) begin
            if (i > 1) tick();
            #1 chk("R3 max count", int'(tmr_out), exp_wave(0, 16383, i));
        end
        tick();

        // R11: readback of halved state, even and odd counts
        load(2'b01, 10);
        cmd(C_GO);
        rd_chk("R11 n10 s1 low", LO, 5);
        rd_chk("R11 n10 s1 high", HI, 8'h40);
        tick(); tick();
        rd_chk("R11 n10 s3 low", LO, 3);
        tick(); tick(); tick();
        rd_chk("R11 n10 s6 low", LO, 5);
        cmd(C_HALT);
        load(2'b01, 9);
        cmd(C_GO);
        rd_chk("R11 n9 s1 low", LO, 5);
        repeat (4) tick();
        rd_chk("R11 n9 s5 low", LO, 1);
        tick();
        rd_chk("R11 n9 s6 low", LO, 4);
        cmd(C_HALT);

        // R7 R1: deferred START, writes before and after it
        load(2'b01, 6);
        cmd(C_GO);
        for (int i = 1; i <= 14; i++) begin
            #1 chk("R7 R1 deferred start", int'(tmr_out),
                   i <= 6 ? exp_wave(1, 6, i) : exp_wave(1, 4, i - 6));
            reg_we = 1'b0; cmd_we = 1'b0;
            case (i)
                2: begin reg_we = 1'b1; reg_addr = LO; reg_wdata = 8'd4; end
                3: begin reg_we = 1'b1; reg_addr = HI; reg_wdata = 8'h40; end
                4: begin cmd_we = 1'b1; cmd_wdata = {C_GO, 6'b0}; end
                5: begin reg_we = 1'b1; reg_addr = LO; reg_wdata = 8'd12; end
                default: ;
            endcase
            tick();
        end
        reg_we = 1'b0; cmd_we = 1'b0;
        cmd(C_HALT);

        // R9: stop after terminal count
        load(2'b01, 5);
        cmd(C_GO);
        for (int i = 1; i <= 10; i++) begin
            #1 chk("R9 stop after tc", int'(tmr_out), i <= 5 ? exp_wave(1, 5, i) : 1);
            cmd_we = (i == 2); cmd_wdata = {C_HALT_TC, 6'b0};
            tick();
        end
        cmd_we = 1'b0;

        // R8: immediate stop
        load(2'b01, 8);
        cmd(C_GO);
        for (int i = 1; i <= 10; i++) begin
            #1 chk("R8 immediate stop", int'(tmr_out), i <= 3 ? exp_wave(1, 8, i) : 1);
            cmd_we = (i == 3); cmd_wdata = {C_HALT, 6'b0};
            tick();
        end
        cmd_we = 1'b0;

        // R6: NOP while running has no effect
        load(2'b11, 7);
        cmd(C_GO);
        for (int i = 1; i <= 21; i++) begin
            #1 chk("R6 nop while running", int'(tmr_out), exp_wave(3, 7, i));
            cmd_we = (i == 3); cmd_wdata = {C_NOP, 6'b0};
            tick();
        end
        cmd_we = 1'b0;
        cmd(C_HALT);

        // R10: reset during a run
        load(2'b01, 6);
        cmd(C_GO);
        for (int i = 1; i <= 14; i++) begin
            #1 chk("R10 reset mid run", int'(tmr_out), i <= 2 ? exp_wave(1, 6, i) : 1);
            rst = (i == 2);
            tick();
        end
        rst = 1'b0;

        finish_run();
    end
endmodule